// File: doc/BRIEF.md
# Watchdog Timer with Boot Grace Period

This block is a digital watchdog for a safety controller. It supervises a host processor through a single trigger line. After power-on reset its active-low fault output stays inactive for a fixed grace period, so the host has time to boot. The first trigger from the host ends the grace period at once and starts timeout monitoring. If the grace period runs out with no trigger, the block raises a fault.

During monitoring, every valid trigger restarts the timeout. A 2-bit mode input selects one of three timeout lengths, or switches the watchdog off. When it is off, the fault output is held inactive. An optional window check treats a trigger that comes too soon as a fault, in the same way as a missing one. A strap input picks between two kinds of fault. A latched fault holds until the next power-on reset. A non-latched fault is a fixed-width low pulse, after which the grace period starts again. All times are parameters counted in clock cycles.

In the requirements below, "edge k" means the k-th rising clock edge after `rst_ni` is released. T is the timeout selected by the mode, and L is T/4, rounded down.

Top module: `wdt_boot_guard`

## Requirements
- R1: While `rst_ni` is low, `wdo_n_o` is 1. If no trigger arrives, `wdo_n_o` stays 1 through edge BOOT_CYC-1 and goes to 0 at edge BOOT_CYC.
- R2: `trig_i` passes through a two-stage synchronizer. A rising edge of `trig_i` first sampled at clock edge j takes effect at edge j+2. Holding `trig_i` high, or letting it fall, has no effect.
- R3: A trigger that takes effect at edge s during the grace period ends the grace period and starts monitoring. With no further trigger, `wdo_n_o` goes to 0 at edge s+T.
- R4: The mode encodes the timeout as follows: 2'b00 selects TMO_A, 2'b10 selects TMO_B and 2'b11 selects TMO_C. A valid trigger at edge e restarts the timeout, so that `wdo_n_o` falls at edge e+T unless another trigger arrives first.
- R5: Mode 2'b01 switches the watchdog off. `wdo_n_o` is then held at 1, including after the grace period would have expired, and triggers are ignored.
- R6: Leaving mode 2'b01 starts monitoring at edge m, the first edge that samples the new code. With no trigger, `wdo_n_o` falls at edge m+T.
- R7: With WIN_EN=1, a trigger that takes effect d edges after monitoring started or was last restarted is a fault at that edge if d ≤ L. If d > L, it restarts the timeout.
- R8: With `latch_en_i`=0, a fault drives `wdo_n_o` low for exactly PULSE_CYC edges. Then `wdo_n_o` returns to 1 and the grace period restarts.
- R9: With `latch_en_i`=1, a fault holds `wdo_n_o` at 0 until `rst_ni` goes low. Neither triggers nor mode 2'b01 clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| trig_i | input | 1 | Trigger from the host, asynchronous; acted on at its rising edge |
| mode_i | input | 2 | Timeout select; 2'b01 switches the watchdog off |
| latch_en_i | input | 1 | 1 selects a latched fault, 0 selects a pulsed fault |
| wdo_n_o | output | 1 | Registered fault output, active low |

## Verification
The hardest cases to reach from the ports are the lower window boundary and a latched fault that must survive the disable code. For the window, the bench first ends the grace period with a trigger at a known edge. It then sweeps the offset of a second trigger over every value from just after the start of monitoring to just before the timeout, for each of the three timeout codes. The expected result at each offset is computed from d ≤ T/4. For the latch, the bench forces a fault and then keeps applying triggers and the disable code for more than a full grace period, checking that the output stays low on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        WD_BOOT      = 3'd0,
        WD_RUN       = 3'd1,
        WD_FLT_PULSE = 3'd2,
        WD_FLT_HOLD  = 3'd3,
        WD_OFF       = 3'd4
    } wd_state_e;

    localparam logic [1:0] MODE_A   = 2'b00;
    localparam logic [1:0] MODE_OFF = 2'b01;
    localparam logic [1:0] MODE_B   = 2'b10;
    localparam logic [1:0] MODE_C   = 2'b11;

endpackage

// File: rtl/wdt_trig_edge.sv
module wdt_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic edge_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_t;

    edge_t q, d;
    logic [SYNC_STAGES-1:0] shifted;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign shifted = {q.sync[SYNC_STAGES-2:0], trig_i};
        end else begin : g_single
            assign shifted = trig_i;
        end
    endgenerate

    always_comb begin
        d      = q;
        d.sync = shifted;
        d.last = q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign edge_o = q.sync[SYNC_STAGES-1] & ~q.last;

    // R2: a synchronized edge lasts exactly one cycle
    a_r2_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> !edge_o);

endmodule

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel
    import wdt_pkg::*;
#(
    parameter int CW     = 32,
    parameter int TMO_A  = 16,
    parameter int TMO_B  = 24,
    parameter int TMO_C  = 32,
    parameter bit WIN_EN = 1'b1
) (
    input  logic [1:0]    mode_i,
    output logic [CW-1:0] limit_o,
    output logic [CW-1:0] low_o
);

    localparam logic [CW-1:0] LIM_A = CW'(TMO_A);
    localparam logic [CW-1:0] LIM_B = CW'(TMO_B);
    localparam logic [CW-1:0] LIM_C = CW'(TMO_C);
    localparam logic [CW-1:0] LOW_A = CW'(TMO_A / 4);
    localparam logic [CW-1:0] LOW_B = CW'(TMO_B / 4);
    localparam logic [CW-1:0] LOW_C = CW'(TMO_C / 4);

    always_comb begin
        case (mode_i)
            MODE_B:  limit_o = LIM_B;
            MODE_C:  limit_o = LIM_C;
            default: limit_o = LIM_A;
        endcase
    end

    generate
        if (WIN_EN) begin : g_window
            always_comb begin
                case (mode_i)
                    MODE_B:  low_o = LOW_B;
                    MODE_C:  low_o = LOW_C;
                    default: low_o = LOW_A;
                endcase
            end
        end else begin : g_no_window
            assign low_o = '0;
        end
    endgenerate

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CW        = 32,
    parameter int BOOT_CYC  = 40,
    parameter int PULSE_CYC = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          edge_i,
    input  logic [1:0]    mode_i,
    input  logic          latch_en_i,
    input  logic [CW-1:0] limit_i,
    input  logic [CW-1:0] low_i,
    output logic          wdo_n_o
);

    localparam logic [CW-1:0] BOOT_LAST  = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] PULSE_LIM  = CW'(PULSE_CYC);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
        logic          wdo_n;
    } fsm_t;

    fsm_t q, d;
    logic [CW-1:0] cnt_inc;
    logic          fault;

    assign cnt_inc = (&q.cnt) ? q.cnt : q.cnt + CW'(1);

    always_comb begin
        d     = q;
        fault = 1'b0;
        if (q.st == WD_FLT_HOLD) begin
            d.st = WD_FLT_HOLD;
        end else if (mode_i == MODE_OFF) begin
            d.st  = WD_OFF;
            d.cnt = '0;
        end else begin
            case (q.st)
                WD_OFF: begin
                    d.st  = WD_RUN;
                    d.cnt = '0;
                end
                WD_BOOT: begin
                    if (edge_i) begin
                        d.st  = WD_RUN;
                        d.cnt = '0;
                    end else if (q.cnt >= BOOT_LAST) begin
                        fault = 1'b1;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
                WD_RUN: begin
                    if (edge_i) begin
                        if (q.cnt < low_i) fault = 1'b1;
                        else               d.cnt = '0;
                    end else if (q.cnt >= limit_i - CW'(1)) begin
                        fault = 1'b1;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
                WD_FLT_PULSE: begin
                    if (q.cnt >= PULSE_LAST) begin
                        d.st  = WD_BOOT;
                        d.cnt = '0;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
                default: begin
                    d.st  = WD_BOOT;
                    d.cnt = '0;
                end
            endcase
        end
        if (fault) begin
            d.st  = latch_en_i ? WD_FLT_HOLD : WD_FLT_PULSE;
            d.cnt = '0;
        end
        d.wdo_n = !((d.st == WD_FLT_PULSE) || (d.st == WD_FLT_HOLD));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st    <= WD_BOOT;
            q.cnt   <= '0;
            q.wdo_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wdo_n_o = q.wdo_n;

    // R9: a latched fault persists and keeps the output low
    a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_FLT_HOLD) |=> (q.st == WD_FLT_HOLD && !wdo_n_o));

    // R5: disable code forces the output inactive unless latched
    a_r5_off_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_OFF && q.st != WD_FLT_HOLD) |=> wdo_n_o);

    // R8: the pulse counter stays within the pulse width
    a_r8_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_FLT_PULSE) |-> (q.cnt < PULSE_LIM));

    // R3: a trigger during the grace period starts monitoring
    a_r3_boot_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_BOOT && edge_i && mode_i != MODE_OFF) |=> (q.st == WD_RUN && q.cnt == '0));

    // R6: leaving the disable code starts monitoring
    a_r6_off_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_OFF && mode_i != MODE_OFF) |=> (q.st == WD_RUN));

endmodule

// File: rtl/wdt_boot_guard.sv
module wdt_boot_guard #(
    parameter int CNT_W       = 32,
    parameter int BOOT_CYC    = 1_250_000_000,
    parameter int TMO_A       = 12_500_000,
    parameter int TMO_B       = 125_000_000,
    parameter int TMO_C       = 250_000_000,
    parameter int PULSE_CYC   = 125_000,
    parameter bit WIN_EN      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       trig_i,
    input  logic [1:0] mode_i,
    input  logic       latch_en_i,
    output logic       wdo_n_o
);

    logic             trig_edge;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] low;

    wdt_trig_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .trig_i(trig_i),
        .edge_o(trig_edge)
    );

    wdt_limit_sel #(
        .CW    (CNT_W),
        .TMO_A (TMO_A),
        .TMO_B (TMO_B),
        .TMO_C (TMO_C),
        .WIN_EN(WIN_EN)
    ) u_limit (
        .mode_i (mode_i),
        .limit_o(limit),
        .low_o  (low)
    );

    wdt_fsm #(
        .CW       (CNT_W),
        .BOOT_CYC (BOOT_CYC),
        .PULSE_CYC(PULSE_CYC)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .edge_i    (trig_edge),
        .mode_i    (mode_i),
        .latch_en_i(latch_en_i),
        .limit_i   (limit),
        .low_i     (low),
        .wdo_n_o   (wdo_n_o)
    );

endmodule

// File: tb/tb_wdt_boot_guard.sv
`timescale 1ns/1ps
module tb_wdt_boot_guard;

    localparam int BOOT  = 40;
    localparam int TA    = 16;
    localparam int TB    = 24;
    localparam int TC    = 32;
    localparam int PULSE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       latch = 1'b0;
    logic       wdo_n;
    int         cyc = 0;
    int         vectors = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    wdt_boot_guard #(
        .CNT_W(16), .BOOT_CYC(BOOT), .TMO_A(TA), .TMO_B(TB), .TMO_C(TC),
        .PULSE_CYC(PULSE), .WIN_EN(1'b1), .SYNC_STAGES(2)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mode_i(mode),
        .latch_en_i(latch), .wdo_n_o(wdo_n)
    );

    function automatic int tmo(input logic [1:0] m);
        case (m)
            2'b10:   return TB;
            2'b11:   return TC;
            default: return TA;
        endcase
    endfunction

    task automatic chk(input logic exp, input string req, input string what);
        vectors++;
        if (wdo_n !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: got %b expected %b", req, what, cyc, wdo_n, exp);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic l);
        @(negedge clk);
        rst_n = 1'b0;
        trig  = 1'b0;
        mode  = m;
        latch = l;
        repeat (3) @(negedge clk);
        chk(1'b1, "R1", "output during reset");
        rst_n = 1'b1;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1 / R8: grace expiry and pulsed fault
        do_reset(2'b00, 1'b0);
        wait_to(BOOT - 1); chk(1'b1, "R1", "before grace end");
        wait_to(BOOT);     chk(1'b0, "R1", "grace expiry");
        wait_to(BOOT + PULSE - 1); chk(1'b0, "R8", "pulse last low");
        wait_to(BOOT + PULSE);     chk(1'b1, "R8", "pulse end");
        wait_to(2 * BOOT + PULSE - 1); chk(1'b1, "R8", "restarted grace");
        wait_to(2 * BOOT + PULSE);     chk(1'b0, "R8", "second grace expiry");

        // R8: trigger in restarted grace period
        do_reset(2'b00, 1'b0);
        wait_to(BOOT + PULSE + 5); pulse_trig();
        wait_to(BOOT + PULSE + 8 + TA - 1); chk(1'b1, "R8", "monitor after restart");
        wait_to(BOOT + PULSE + 8 + TA);     chk(1'b0, "R8", "timeout after restart");

        // R2 / R3 / R4 / R7: window sweep for every timeout code
        for (int mi = 0; mi < 3; mi++) begin
            logic [1:0] m;
            int t;
            m = (mi == 0) ? 2'b00 : (mi == 1) ? 2'b10 : 2'b11;
            t = tmo(m);
            do_reset(m, 1'b0);
            wait_to(5); pulse_trig();
            wait_to(8 + t - 1); chk(1'b1, "R3", "grace ended, before timeout");
            wait_to(8 + t);     chk(1'b0, "R3", "timeout after first trigger");
            for (int d = 2; d < t; d++) begin
                do_reset(m, 1'b0);
                wait_to(5); pulse_trig();
                wait_to(5 + d); pulse_trig();
                wait_to(8 + d - 1); chk(1'b1, "R2", "before second trigger acts");
                wait_to(8 + d);
                if (d <= t / 4) begin
                    chk(1'b0, "R7", "early trigger fault");
                end else begin
                    chk(1'b1, "R7", "late trigger accepted");
                    wait_to(8 + d + t - 1); chk(1'b1, "R4", "restarted timeout");
                    wait_to(8 + d + t);     chk(1'b0, "R4", "restarted timeout expiry");
                end
            end
        end

        // R2: held-high level and falling edge ignored
        do_reset(2'b00, 1'b0);
        wait_to(5); trig = 1'b1;
        wait_to(12); trig = 1'b0;
        wait_to(8 + TA - 1); chk(1'b1, "R2", "held level before timeout");
        wait_to(8 + TA);     chk(1'b0, "R2", "no retrigger from level or fall");

        // R5 / R6: disabled, then enabled with 2'b00
        do_reset(2'b01, 1'b0);
        for (int c = 1; c <= 100; c++) begin
            wait_to(c);
            chk(1'b1, "R5", "disabled output");
            trig = (c == 20 || c == 60);
        end
        mode = 2'b00;
        wait_to(101 + TA - 1); chk(1'b1, "R6", "after enable, before timeout");
        wait_to(101 + TA);     chk(1'b0, "R6", "after enable timeout");

        // R6: enabled with 2'b11
        do_reset(2'b01, 1'b0);
        wait_to(50); mode = 2'b11;
        wait_to(51 + TC - 1); chk(1'b1, "R6", "mode 11 before timeout");
        wait_to(51 + TC);     chk(1'b0, "R6", "mode 11 timeout");

        // R9: latched fault
        do_reset(2'b00, 1'b1);
        wait_to(BOOT); chk(1'b0, "R9", "latched fault set");
        for (int c = BOOT + 1; c <= BOOT + 120; c++) begin
            wait_to(c);
            chk(1'b0, "R9", "latched fault hold");
            trig = (c == 45 || c == 70);
            if (c == 50) mode = 2'b01;
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1'b1, "R9", "cleared by reset");
        mode = 2'b00; latch = 1'b0; trig = 1'b0;
        rst_n = 1'b1;
        wait_to(3); chk(1'b1, "R9", "after reset release");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule